// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block turns a free-running parent clock into a clock-enable pulse train whose average rate is N/32 of the parent rate, with N between 1 and 32. It works by pulse swallowing: in every frame of 32 parent cycles exactly N enable pulses are passed, and an accumulator spreads them evenly across the frame instead of grouping them together. Downstream logic stays on the parent clock and advances only in cycles where the enable is high.

Software programs the block over a small 32-bit register bus with two words. The control word carries a 5-bit rate code that holds 32 minus the wanted multiplier, so a code of 0 means full rate. Writing the code alone changes nothing at the output. Software must then set the request bit in the kick word. The hardware applies the new multiplier at the next frame boundary and clears the request bit in the same cycle, so software polls that bit to learn when the change is done. While a request is pending, writes to the control word are dropped, so that the value being applied cannot be corrupted.

Top module: `frc_top`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0 and the kick word reads 0. `clk_en` is high in every cycle (multiplier 32).
- R2: The rate code sits in control bits 12:8. The applied multiplier is 32 minus the code, and `clk_en` is high in exactly that many cycles of each 32-cycle frame. Frames start on the first clock edge after reset is released.
- R3: For any multiplier of 16 or less, `clk_en` is never high in two adjacent cycles within one frame.
- R4: Writing a word with bit 31 set to the kick address (byte offset 4) raises the request bit, which then reads back as bit 31 of the kick word.
- R5: A pending request is applied only at the edge that closes a frame. The request bit reads 1 up to the last cycle of that frame and 0 from the first cycle of the next frame. The old rate stays in force until that edge.
- R6: While a request is pending, writes to the control word (byte offset 0) are dropped whole, and the rate that gets applied is the code held before the request.
- R7: The control word stores and returns all 32 bits. Bits outside 12:8 have no effect on the rate.
- R8: Changing the rate code without a kick leaves the output rate unchanged.
- R9: Writing the kick word with bit 31 clear has no effect. The other kick-word bits always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address: 0 = control word, 4 = kick word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_en | output | 1 | Fractional clock-enable pulse train |

## Verification
On every cycle the embedded assertions check the following:
- The request bit drops only at a frame-closing edge.
- The shadow multiplier changes only when a request is applied.
- The accumulator is back at zero at each frame start.
- The number of pulses in each frame equals the active multiplier.
- Low rates never produce back-to-back pulses.
- A control write made while a request is pending leaves the word untouched.

The timing of the switch-over can only be shown by the bench scenarios. These cover:
- the old rate still in force in the last cycle before the boundary;
- the request bit read as set at cycle 31 and clear at cycle 0;
- that control bits outside the rate field do not affect the rate;
- that a kick write without bit 31 is ignored;
- that a mid-run reset restores full rate.

// File: rtl/frc_pkg.sv
// Shared constants for the fractional clock rate controller.
// Assumes byte addressing on a 32-bit register bus.
package frc_pkg;
    localparam int unsigned FRC_CTRL_OFS  = 0;   // control word offset
    localparam int unsigned FRC_KICK_OFS  = 4;   // kick word offset
    localparam int unsigned FRC_FIELD_LSB = 8;   // rate code position
    localparam int unsigned FRC_KICK_BIT  = 31;  // request bit position
endpackage

// File: rtl/frc_regs.sv
// Register file: control word (rate code plus free bits) and kick request.
// Assumes one write per cycle and a combinational read path; the request
// is consumed when the frame timer signals the end of a frame.
module frc_regs #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int FRAME_W   = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter int CTRL_ADDR = 0,
    parameter int KICK_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_end,
    output logic [FRAME_W-1:0] rate_code,
    output logic              apply
);
    logic [DATA_W-1:0] ctrl_q;
    logic              kick_q;
    logic              ctrl_wr;
    logic              kick_set;

    assign ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign kick_set  = bus_wr && (bus_addr == ADDR_W'(KICK_ADDR)) && bus_wdata[KICK_BIT];
    assign apply     = kick_q && frame_end;
    assign rate_code = ctrl_q[FIELD_LSB +: FRAME_W];

    // Control word: full-width store, locked while a request is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr && !kick_q)
            ctrl_q <= bus_wdata;
    end

    // Request bit: set by software, cleared by hardware when applied.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kick_q <= 1'b0;
        else if (apply)
            kick_q <= 1'b0;
        else if (kick_set)
            kick_q <= 1'b1;
    end

    // Read mux: request bit alone in the kick word, zeros elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata = ctrl_q;
        else if (bus_addr == ADDR_W'(KICK_ADDR))
            bus_rdata[KICK_BIT] = kick_q;
    end

    // R5
    kick_clear_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick_q) |-> $past(frame_end));

    // R6
    busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_wr && kick_q) |-> $stable(ctrl_q));
endmodule

// File: rtl/frc_frame.sv
// Frame timer and shadow multiplier. Counts parent cycles in frames of
// 2**FRAME_W and loads the multiplier (frame size minus code) only on apply.
// Assumes apply is asserted only in the frame's last cycle.
module frc_frame #(
    parameter int FRAME_W = 5,
    localparam int FRAME  = 1 << FRAME_W,
    localparam int MULT_W = FRAME_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  logic [FRAME_W-1:0] rate_code,
    output logic               frame_start,
    output logic               frame_end,
    output logic [MULT_W-1:0]  mult
);
    logic [FRAME_W-1:0] cnt_q;
    logic [MULT_W-1:0]  mult_q;

    assign frame_start = (cnt_q == '0);
    assign frame_end   = (cnt_q == FRAME_W'(FRAME - 1));
    assign mult        = mult_q;

    // Cycle position within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Shadow multiplier: full rate after reset, reloaded at frame close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mult_q <= MULT_W'(FRAME);
        else if (apply)
            mult_q <= MULT_W'(FRAME) - {1'b0, rate_code};
    end

    // R5
    mult_only_on_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_q != $past(mult_q)) |-> $past(apply));
endmodule

// File: rtl/frc_accum.sv
// Phase accumulator: adds the multiplier each cycle modulo the frame size
// and emits an enable on carry, spreading pulses evenly across the frame.
// Assumes the multiplier is constant within a frame and lies in 1..FRAME.
module frc_accum #(
    parameter int FRAME_W = 5,
    localparam int FRAME  = 1 << FRAME_W,
    localparam int HALF   = FRAME / 2,
    localparam int MULT_W = FRAME_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MULT_W-1:0] mult,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic              pulse
);
    logic [FRAME_W-1:0] acc_q;
    logic [MULT_W-1:0]  sum;
    logic [MULT_W-1:0]  seen_q;

    assign sum   = {1'b0, acc_q} + mult;
    assign pulse = sum[FRAME_W];

    // Phase register: keeps the remainder after each carry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= sum[FRAME_W-1:0];
    end

    // Pulses seen so far in this frame, for the per-frame count check.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end)
            seen_q <= '0;
        else
            seen_q <= seen_q + MULT_W'(pulse);
    end

    // R2
    acc_zero_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (acc_q == '0));

    // R2
    pulses_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ((seen_q + MULT_W'(pulse)) == mult));

    // R3
    no_adjacent_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !frame_end && (mult <= MULT_W'(HALF))) |=> !pulse);
endmodule

// File: rtl/frc_top.sv
// Fractional clock rate controller: register file, frame timer with shadow
// multiplier, and pulse-swallowing accumulator. Output is a clock enable
// on the parent clock domain; all state resets synchronously, active low.
module frc_top
    import frc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int FRAME_W = 5,
    localparam int MULT_W = FRAME_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_en
);
    logic [FRAME_W-1:0] rate_code;
    logic               apply;
    logic               frame_start;
    logic               frame_end;
    logic [MULT_W-1:0]  mult;

    frc_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .FRAME_W   (FRAME_W),
        .FIELD_LSB (int'(FRC_FIELD_LSB)),
        .KICK_BIT  (int'(FRC_KICK_BIT)),
        .CTRL_ADDR (int'(FRC_CTRL_OFS)),
        .KICK_ADDR (int'(FRC_KICK_OFS))
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .frame_end (frame_end),
        .rate_code (rate_code),
        .apply     (apply)
    );

    frc_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (apply),
        .rate_code   (rate_code),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .mult        (mult)
    );

    frc_accum #(.FRAME_W(FRAME_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .mult        (mult),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .pulse       (clk_en)
    );
endmodule

// File: tb/tb_frc_top.sv
`timescale 1ns/1ps
module tb_frc_top;
    localparam logic [3:0]  A_CTRL   = 4'h0;
    localparam logic [3:0]  A_KICK   = 4'h4;
    localparam logic [31:0] KICK_REQ = 32'h8000_0000;
    localparam int          NVEC     = 8;
    // {rate code, expected pulses per frame}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00_20, 16'h1F_01, 16'h10_10, 16'h01_1F,
        16'h14_0C, 16'h08_18, 16'h18_08, 16'h0F_11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_en;
    logic [4:0]  ph;
    int checks = 0;
    int failures = 0;

    frc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en)
    );

    always #2.5 clk = ~clk;

    // Frame position model: frames start at the first edge after reset.
    always @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + 5'd1;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Count pulses over one whole frame; flag adjacent pulses in it.
    task automatic measure_frame(output int cnt, output bit adj);
        bit prev = 1'b0;
        cnt = 0; adj = 1'b0;
        @(negedge clk);
        while (ph != 5'd0) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            if (clk_en) cnt++;
            if (clk_en && prev) adj = 1'b1;
            prev = clk_en;
            @(negedge clk);
        end
    endtask

    task automatic wait_kick_clear(input string req);
        logic [31:0] d;
        int n = 0;
        bus_read(A_KICK, d);
        while (d[31] && n < 100) begin
            bus_read(A_KICK, d);
            n++;
        end
        check(req, d, 32'h0);
    endtask

    task automatic apply_rate(input logic [4:0] code, input int exp);
        logic [31:0] cur;
        int cnt; bit adj;
        bus_read(A_CTRL, cur);
        bus_write(A_CTRL, (cur & ~32'h0000_1F00) | (32'(code) << 8));
        bus_write(A_KICK, KICK_REQ);
        wait_kick_clear("R4 kick self-clear");
        measure_frame(cnt, adj);
        check("R2 pulses per frame", 32'(cnt), 32'(exp));
        if (exp <= 16) check("R3 no adjacent pulses", 32'(adj), 32'h0);
    endtask

    initial begin
        #500000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt; bit adj;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(A_CTRL, d); check("R1 ctrl after reset", d, 32'h0);
        bus_read(A_KICK, d); check("R1 kick after reset", d, 32'h0);
        measure_frame(cnt, adj); check("R1 full rate", 32'(cnt), 32'd32);

        // R2/R3: table of rates
        for (int i = 0; i < NVEC; i++)
            apply_rate(VEC[i][12:8], int'(VEC[i][7:0]));

        // R5/R6: request mid-frame, busy write dropped, switch at boundary
        apply_rate(5'd0, 32);
        bus_write(A_CTRL, 32'h0000_1800);
        @(negedge clk);
        while (ph != 5'd5) @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_KICK; bus_wdata = KICK_REQ;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R4 kick reads set", bus_rdata, KICK_REQ);
        while (ph != 5'd10) @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0000_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        while (ph != 5'd20) @(negedge clk);
        bus_addr = A_CTRL;
        #1 check("R6 ctrl unchanged while busy", bus_rdata, 32'h0000_1800);
        while (ph != 5'd30) @(negedge clk);
        bus_addr = A_KICK;
        #1 check("R5 old rate before boundary", 32'(clk_en), 32'h1);
        @(negedge clk);
        #1 check("R5 kick set in last cycle", bus_rdata, KICK_REQ);
        @(negedge clk);
        #1 check("R5 kick clear at frame start", bus_rdata, 32'h0);
        measure_frame(cnt, adj); check("R6 pre-request code applied", 32'(cnt), 32'd8);

        // R8: code change without kick
        bus_write(A_CTRL, 32'h0000_1F00);
        measure_frame(cnt, adj); check("R8 rate unchanged w/o kick", 32'(cnt), 32'd8);
        bus_read(A_CTRL, d); check("R8 ctrl holds new code", d, 32'h0000_1F00);

        // R9: kick write without request bit
        bus_write(A_KICK, 32'h7FFF_FFFF);
        bus_read(A_KICK, d); check("R9 kick stays clear", d, 32'h0);
        measure_frame(cnt, adj); check("R9 rate unchanged", 32'(cnt), 32'd8);

        // R7: full-width control word, free bits have no rate effect
        bus_write(A_CTRL, 32'hDEAD_F3C1);
        bus_read(A_CTRL, d); check("R7 ctrl readback", d, 32'hDEAD_F3C1);
        bus_write(A_KICK, KICK_REQ);
        wait_kick_clear("R4 kick self-clear");
        measure_frame(cnt, adj); check("R7 rate from bits 12:8 only", 32'(cnt), 32'd13);
        check("R3 no adjacent at 13", 32'(adj), 32'h0);

        // R1: reset mid-run restores full rate
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read(A_CTRL, d); check("R1 ctrl after re-reset", d, 32'h0);
        measure_frame(cnt, adj); check("R1 full rate after re-reset", 32'(cnt), 32'd32);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule